// File: doc/BRIEF.md
# Multi-Mode Serial Shift Register

This block moves one byte between a parallel register and a serial data line under a bit clock. A three-bit mode input selects where that bit clock comes from: a programmable divider driven by a reload value `rate_n`, the system clock itself, or an external clock pin. The block either shifts data in from the serial line or rotates it out onto the line. A modulo-8 bit counter raises a transfer-complete flag once a byte has passed. Software-style access strobes (`reg_wr`, `reg_rd`) load or read the register. In the internally clocked modes, each access also starts a fresh byte transfer.

The control is a four-state machine. IDLE holds the bit clock high. LOW and HIGH are the two phases of an internally generated bit clock. EXT is used while the clock comes from outside. The transitions are:

- **Start:** any access in an internal mode moves the machine to LOW from every state, and restarts a transfer already in progress.
- **Rise:** a divider tick in LOW moves it to HIGH.
- **Stop:** the eighth rise of a one-shot transfer moves it to IDLE instead of HIGH, leaving the clock high.
- **Fall:** a tick in HIGH moves it back to LOW.
- **External mode:** selecting an external-clock mode sends the machine to EXT.
- **Off:** selecting the off mode sends it to IDLE.

Top module: `ser_shifter`

## Requirements
- R1: With `mode_sel` = 000 the register is written and read normally. It never shifts, and a read starts nothing. `xfer_flag` stays 0, neither `sclk_oe` nor `sdata_oe` is asserted, and `sclk_out` rests at 1.
- R2: In the shift-out modes (`mode_sel` = 100, 101, 110, 111), bit 7 goes out first on `sdata_out`. The register rotates left, so bit 7 re-enters at bit 0. After eight bits `rd_data` again equals the byte written.
- R3: In the shift-in modes (`mode_sel` = 001, 010, 011), each new bit from `sdata_in` enters at bit 0 and moves toward bit 7. After eight bits, the first bit received sits in bit 7.
- R4: In modes 001, 100 and 101, each phase of the generated bit clock on `sclk_out` lasts `rate_n`+2 system clocks.
- R5: In modes 010 and 110, each phase of the generated bit clock lasts one system clock.
- R6: In modes 001, 010, 101 and 110, an access starts a transfer: `sclk_out` goes low at that edge. The eighth rise of `sclk_out` stops the clock at 1. `xfer_flag` sets one clock after that rise, which is 15·H+1 clocks after the access edge, where H is the phase length. In shift-out, `sdata_out` keeps the last bit sent (original bit 0).
- R7: Any access clears `xfer_flag` and restarts the bit count. An access during a transfer restarts it with full timing.
- R8: Mode 100 keeps clocking and recirculating the same byte after eight bits, and never sets `xfer_flag`.
- R9: In modes 011 and 111, `sclk_in` is synchronized and used as the bit clock. Each rising edge shifts one bit in (011), and each falling edge presents the next bit on `sdata_out` (111). `xfer_flag` sets after every eighth rise, and shifting carries on after that.
- R10: In the internally clocked shift-in modes, `sdata_in` is sampled in the system clock cycle after each rise of `sclk_out`, not at the rise itself.
- R11: `sclk_oe` is 1 exactly in modes 001, 010, 100, 101 and 110. `sdata_oe` is 1 exactly in modes 100 to 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 3 | Operating mode |
| rate_n | input | RW | Divider reload value N for the timer-rate modes |
| reg_wr | input | 1 | Write strobe: loads `wr_data` |
| reg_rd | input | 1 | Read strobe: access without load |
| wr_data | input | DW | Byte to load |
| rd_data | output | DW | Current register contents |
| sclk_in | input | 1 | External bit clock |
| sclk_out | output | 1 | Generated bit clock |
| sclk_oe | output | 1 | Bit clock drive enable |
| sdata_in | input | 1 | Serial data input |
| sdata_out | output | 1 | Serial data output |
| sdata_oe | output | 1 | Serial data drive enable |
| xfer_flag | output | 1 | Byte transfer complete flag |

## Verification
The bench measures the flag time in system clocks from the starting access, across random divider values and modes. A divider off by one cycle, or a flag raised at the rise rather than one cycle after it, lands 15 or 1 clocks off the expected count. Serial data is changed right after each observed clock fall. With the one-cycle phase, a design that samples a cycle late therefore captures the wrong bit, and one that rotates the wrong way returns a mirrored byte. A mid-transfer access, a ninth external pulse after the flag, and a long run in the free-running mode catch designs that fail to restart, stop the external count, or raise the flag where it must stay clear.

// File: rtl/ss_pkg.sv
package ss_pkg;

    typedef enum logic [2:0] {
        M_OFF      = 3'd0,
        M_IN_TMR   = 3'd1,
        M_IN_SYS   = 3'd2,
        M_IN_EXT   = 3'd3,
        M_OUT_FREE = 3'd4,
        M_OUT_TMR  = 3'd5,
        M_OUT_SYS  = 3'd6,
        M_OUT_EXT  = 3'd7
    } ss_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_EXT  = 2'd3
    } ss_state_e;

    function automatic logic mode_is_ext(ss_mode_e m);
        return (m == M_IN_EXT) || (m == M_OUT_EXT);
    endfunction

    function automatic logic mode_is_sys(ss_mode_e m);
        return (m == M_IN_SYS) || (m == M_OUT_SYS);
    endfunction

    function automatic logic mode_is_out(ss_mode_e m);
        return (m == M_OUT_FREE) || (m == M_OUT_TMR) ||
               (m == M_OUT_SYS) || (m == M_OUT_EXT);
    endfunction

    function automatic logic mode_is_int(ss_mode_e m);
        return (m != M_OFF) && !mode_is_ext(m);
    endfunction

endpackage

// File: rtl/ss_rate_gen.sv
// Phase divider: one tick every H cycles while running, H = 1 (fast) or N+2.
module ss_rate_gen #(
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          run,
    input  logic          fast,
    input  logic [RW-1:0] rate_n,
    output logic          tick
);
    localparam int CW = RW + 1;

    logic [CW-1:0] div_q;
    logic [CW-1:0] reload;

    assign reload = fast ? '0 : ({1'b0, rate_n} + CW'(1));
    assign tick   = run && !start && (div_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (start) begin
            div_q <= reload;
        end else if (run) begin
            div_q <= (div_q == '0) ? reload : (div_q - CW'(1));
        end
    end

    // R5: in the fast setting a running divider ticks on every cycle
    a_r5_fast_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !start && fast && $past(fast) && $past(run || start)) |-> tick);

endmodule

// File: rtl/ss_edge_sync.sv
// Synchronizer for the external bit clock with rise and fall detection.
module ss_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] chain_q;

    generate
        for (genvar i = 0; i <= STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[i] <= 1'b1;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall = ~chain_q[STAGES-1] & chain_q[STAGES];

endmodule

// File: rtl/ss_bit_counter.sv
// Modulo-DW bit counter; last is high while the count sits at DW-1.
module ss_bit_counter #(
    parameter int DW = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] MAXV = CW'(DW - 1);

    logic [CW-1:0] cnt_q;

    assign last = (cnt_q == MAXV);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= last ? '0 : (cnt_q + CW'(1));
        end
    end

    // R9: after the eighth counted bit the count wraps to zero and keeps going
    a_r9_count_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && last) |=> (cnt_q == '0));

endmodule

// File: rtl/ser_shifter.sv
module ser_shifter #(
    parameter int DW          = 8,
    parameter int RW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    mode_sel,
    input  logic [RW-1:0] rate_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    input  logic          sclk_in,
    output logic          sclk_out,
    output logic          sclk_oe,
    input  logic          sdata_in,
    output logic          sdata_out,
    output logic          sdata_oe,
    output logic          xfer_flag
);
    import ss_pkg::*;

    ss_mode_e  m;
    ss_state_e st_q, st_d;

    logic [DW-1:0] shreg_q;
    logic          sclk_q;
    logic          sdo_q;
    logic          flag_q;
    logic          samp_pend_q;
    logic          fin_pend_q;

    logic access, start, run, tick;
    logic int_mode, ext_mode, out_mode;
    logic rise_int, fall_int;
    logic ext_rise, ext_fall;
    logic cnt_inc, cnt_last;

    assign m        = ss_mode_e'(mode_sel);
    assign access   = reg_wr | reg_rd;
    assign int_mode = mode_is_int(m);
    assign ext_mode = mode_is_ext(m);
    assign out_mode = mode_is_out(m);
    assign start    = access && int_mode;
    assign run      = (st_q == ST_LOW) || (st_q == ST_HIGH);
    assign rise_int = tick && int_mode && (st_q == ST_LOW);
    assign fall_int = tick && int_mode && (st_q == ST_HIGH);
    assign cnt_inc  = rise_int || (ext_mode && ext_rise);

    ss_rate_gen #(.RW(RW)) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .run    (run),
        .fast   (mode_is_sys(m)),
        .rate_n (rate_n),
        .tick   (tick)
    );

    ss_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sclk_in),
        .rise     (ext_rise),
        .fall     (ext_fall)
    );

    ss_bit_counter #(.DW(DW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (access),
        .inc   (cnt_inc),
        .last  (cnt_last)
    );

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (m == M_OFF) begin
            st_d = ST_IDLE;
        end else if (ext_mode) begin
            st_d = ST_EXT;
        end else if (access) begin
            st_d = ST_LOW;
        end else begin
            unique case (st_q)
                ST_IDLE: st_d = ST_IDLE;
                ST_LOW: begin
                    if (tick) begin
                        st_d = (cnt_last && (m != M_OUT_FREE)) ? ST_IDLE : ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (tick) st_d = ST_LOW;
                end
                ST_EXT:  st_d = ST_IDLE;
            endcase
        end
    end

    // State register; the generated clock is low only in LOW
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            sclk_q <= 1'b1;
        end else begin
            st_q   <= st_d;
            sclk_q <= (st_d != ST_LOW);
        end
    end

    // Datapath and flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q     <= '0;
            sdo_q       <= 1'b0;
            flag_q      <= 1'b0;
            samp_pend_q <= 1'b0;
            fin_pend_q  <= 1'b0;
        end else begin
            samp_pend_q <= rise_int && !out_mode && !access;
            fin_pend_q  <= rise_int && cnt_last && (m != M_OUT_FREE) && !access;

            if (reg_wr) begin
                sdo_q   <= wr_data[DW-1];
                shreg_q <= (start && out_mode) ? {wr_data[DW-2:0], wr_data[DW-1]} : wr_data;
            end else if (reg_rd && start && out_mode) begin
                sdo_q   <= shreg_q[DW-1];
                shreg_q <= {shreg_q[DW-2:0], shreg_q[DW-1]};
            end else if ((fall_int && out_mode) || ((m == M_OUT_EXT) && ext_fall)) begin
                sdo_q   <= shreg_q[DW-1];
                shreg_q <= {shreg_q[DW-2:0], shreg_q[DW-1]};
            end else if ((samp_pend_q && int_mode && !out_mode) ||
                         ((m == M_IN_EXT) && ext_rise)) begin
                shreg_q <= {shreg_q[DW-2:0], sdata_in};
            end

            if (m == M_OFF) begin
                flag_q <= 1'b0;
            end else if (access) begin
                flag_q <= 1'b0;
            end else if (fin_pend_q && (m != M_OUT_FREE)) begin
                flag_q <= 1'b1;
            end else if (ext_mode && cnt_inc && cnt_last) begin
                flag_q <= 1'b1;
            end
        end
    end

    // Outputs
    assign rd_data   = shreg_q;
    assign sclk_out  = sclk_q;
    assign sdata_out = sdo_q;
    assign xfer_flag = flag_q;
    assign sclk_oe   = int_mode;
    assign sdata_oe  = out_mode;

    // R1: the off mode keeps the flag clear and the clock at rest
    a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (m == M_OFF) |=> (!flag_q && sclk_q));

    // R8: the free-running mode never raises the flag
    a_r8_free_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> ($past(m) != M_OUT_FREE));

    // R6: when an internal one-shot transfer completes, the clock is parked high
    a_r6_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag_q) && mode_is_int($past(m))) |-> sclk_q);

    // R2: data only changes on a clock fall or an access, never while high
    a_r2_data_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_HIGH) && !$past(access)) |-> $stable(sdo_q));

endmodule

// File: tb/tb_ser_shifter.sv
`timescale 1ns/1ps
module tb_ser_shifter;
    localparam int DW = 8;
    localparam int RW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    mode_sel = 3'd0;
    logic [RW-1:0] rate_n = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          sclk_in = 1'b1;
    logic          sclk_out, sclk_oe;
    logic          sdata_in = 1'b0;
    logic          sdata_out, sdata_oe;
    logic          xfer_flag;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    ser_shifter #(.DW(DW), .RW(RW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .rate_n(rate_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .wr_data(wr_data), .rd_data(rd_data),
        .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
        .sdata_in(sdata_in), .sdata_out(sdata_out), .sdata_oe(sdata_oe),
        .xfer_flag(xfer_flag)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int half_of(int md, int n);
        return (md == 2 || md == 6) ? 1 : n + 2;
    endfunction

    function automatic int done_at(int h);
        return 15 * h + 1;
    endfunction

    // called at a negedge; returns at the negedge after the access edge
    task automatic access(input bit wr, input logic [7:0] d);
        reg_wr  = wr;
        reg_rd  = !wr;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        reg_rd = 1'b0;
    endtask

    task automatic ext_pulse(input logic b);
        sdata_in = b;
        sclk_in  = 1'b0;
        repeat (6) @(negedge clk);
        sclk_in  = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic run_in(input int md, input int n, input logic [7:0] b);
        int h = half_of(md, n);
        int cyc = 0;
        int lows = 0;
        bit counting = 1'b1;
        int idx = 7;
        logic prev;
        mode_sel = 3'(md);
        rate_n   = RW'(n);
        sdata_in = b[7];
        access(1'b0, 8'h00);
        check("R7 flag cleared by read", 32'(xfer_flag), 32'd0);
        prev = sclk_out;
        if (sclk_out == 1'b0) lows = 1; else counting = 1'b0;
        while (!xfer_flag && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            if (counting) begin
                if (sclk_out == 1'b0) lows++; else counting = 1'b0;
            end
            if (prev && !sclk_out && idx > 0) begin
                idx--;
                sdata_in = b[idx];
            end
            prev = sclk_out;
        end
        check((h == 1) ? "R5 phase length" : "R4 phase length", 32'(lows), 32'(h));
        check("R6 flag timing", 32'(cyc), 32'(done_at(h)));
        check("R3 R10 byte received", 32'(rd_data), 32'(b));
        check("R6 clock parked", 32'(sclk_out), 32'd1);
        check("R11 data not driven", 32'(sdata_oe), 32'd0);
    endtask

    task automatic run_out(input int md, input int n, input logic [7:0] b);
        int h = half_of(md, n);
        int cyc = 0;
        logic [7:0] cap = '0;
        logic prev;
        mode_sel = 3'(md);
        rate_n   = RW'(n);
        access(1'b1, b);
        check("R2 first bit", 32'(sdata_out), 32'(b[7]));
        prev = sclk_out;
        while (!xfer_flag && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            if (!prev && sclk_out) cap = {cap[6:0], sdata_out};
            prev = sclk_out;
        end
        check("R2 bits sent", 32'(cap), 32'(b));
        check("R6 flag timing", 32'(cyc), 32'(done_at(h)));
        check("R6 last bit held", 32'(sdata_out), 32'(b[0]));
        check("R2 register restored", 32'(rd_data), 32'(b));
        check("R11 drive enables", {30'd0, sclk_oe, sdata_oe}, 32'd3);
    endtask

    initial begin
        logic [7:0] d;
        logic [15:0] cap16;
        bit saw_flag;
        int rises;
        void'($urandom(32'h0000_5EED));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset flag", 32'(xfer_flag), 32'd0);
        check("R1 reset clock", 32'(sclk_out), 32'd1);
        check("R1 reset enables", {30'd0, sclk_oe, sdata_oe}, 32'd0);
        check("R1 reset register", 32'(rd_data), 32'd0);

        // R1: off mode
        mode_sel = 3'd0;
        access(1'b1, 8'h5A);
        ext_pulse(1'b1);
        ext_pulse(1'b0);
        access(1'b0, 8'h00);
        repeat (4) @(negedge clk);
        check("R1 register held", 32'(rd_data), 32'h5A);
        check("R1 flag low", 32'(xfer_flag), 32'd0);
        check("R1 clock idle", 32'(sclk_out), 32'd1);
        check("R1 enables off", {30'd0, sclk_oe, sdata_oe}, 32'd0);

        // directed internal cases
        run_in(2, 0, 8'hB4);
        run_in(1, 3, 8'h61);
        run_out(6, 0, 8'hA5);
        run_out(5, 1, 8'h3C);

        // R7: restart in the middle of a transfer
        mode_sel = 3'd5;
        rate_n   = RW'(2);
        access(1'b1, 8'h0F);
        repeat (10) @(negedge clk);
        check("R7 no flag mid transfer", 32'(xfer_flag), 32'd0);
        run_out(5, 2, 8'hC3);

        // R8: free-running shift-out
        mode_sel = 3'd4;
        rate_n   = RW'(1);
        access(1'b1, 8'h96);
        cap16 = '0;
        saw_flag = 1'b0;
        rises = 0;
        begin
            logic prev = sclk_out;
            for (int i = 0; i < 600 && rises < 16; i++) begin
                @(negedge clk);
                if (xfer_flag) saw_flag = 1'b1;
                if (!prev && sclk_out) begin
                    cap16 = {cap16[14:0], sdata_out};
                    rises++;
                end
                prev = sclk_out;
            end
        end
        check("R8 recirculated stream", 32'(cap16), 32'h9696);
        check("R8 flag never set", 32'(saw_flag), 32'd0);
        mode_sel = 3'd0;
        repeat (2) @(negedge clk);
        check("R1 clock stops when off", 32'(sclk_out), 32'd1);

        // R9: external-clock shift-in
        mode_sel = 3'd3;
        access(1'b0, 8'h00);
        d = 8'hD2;
        for (int i = 7; i >= 1; i--) ext_pulse(d[i]);
        check("R9 no flag before eighth", 32'(xfer_flag), 32'd0);
        ext_pulse(d[0]);
        check("R9 flag after eight", 32'(xfer_flag), 32'd1);
        check("R9 R3 byte in", 32'(rd_data), 32'(d));
        check("R11 clock not driven", 32'(sclk_oe), 32'd0);
        ext_pulse(1'b1);
        check("R9 shifting continues", 32'(rd_data), 32'({d[6:0], 1'b1}));
        check("R9 flag stays", 32'(xfer_flag), 32'd1);
        access(1'b0, 8'h00);
        check("R7 read clears flag", 32'(xfer_flag), 32'd0);
        d = 8'h4B;
        for (int i = 7; i >= 0; i--) ext_pulse(d[i]);
        check("R9 second byte", 32'(rd_data), 32'(d));
        check("R9 second flag", 32'(xfer_flag), 32'd1);

        // R9: external-clock shift-out
        mode_sel = 3'd7;
        d = 8'h71;
        access(1'b1, d);
        begin
            logic [7:0] cap = '0;
            for (int i = 0; i < 8; i++) begin
                sclk_in = 1'b0;
                repeat (6) @(negedge clk);
                sclk_in = 1'b1;
                repeat (6) @(negedge clk);
                cap = {cap[6:0], sdata_out};
            end
            check("R9 R2 bits out ext", 32'(cap), 32'(d));
        end
        check("R2 register restored ext", 32'(rd_data), 32'(d));
        check("R9 flag ext out", 32'(xfer_flag), 32'd1);

        // random internal transfers
        for (int k = 0; k < 8; k++) begin
            int pick = int'($urandom_range(0, 3));
            int md = (pick == 0) ? 1 : (pick == 1) ? 2 : (pick == 2) ? 5 : 6;
            int n = int'($urandom_range(0, 4));
            logic [7:0] rb = 8'($urandom);
            if (md < 4) run_in(md, n, rb);
            else        run_out(md, n, rb);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule